// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block sits on the programmer side of a four-wire serial programming link. It drives the target's reset line, the serial clock and the host-to-target data line, and it samples the target-to-host data line. When it leaves reset it holds the target reset and the clock low, then pulses reset high and waits out a start-up delay. After that it sends the enable frame and checks that the target echoes the sync byte while the third byte is on the wire.

If the echo is wrong, the link is out of step. The block pulses reset again, waits again and repeats the enable frame. When the configured number of attempts has failed, it raises a sticky error flag. Once the link is in sync, the block takes 32-bit commands from a valid/ready port. It shifts each command out MSB first and returns the last byte received. After a command marked as a write, it holds off the next command for a write-settle delay.

The clock half-period comes from an input, so software can slow the link to match the target's own clock. The start-up, reset-pulse and write-settle delays are parameters. By default they are derived from the host clock frequency, and a bench can override them with short values.

Top module: `serprog_host`

## Requirements
- R1: While rst_ni is low, tgt_rst_o, tgt_sck_o, tgt_sdo_o, cmd_ready_o, rsp_valid_o, synced_o and error_o are all 0.
- R2: Each sync attempt starts with tgt_rst_o high for at least PULSE_CYC host cycles. tgt_sck_o stays 0 whenever tgt_rst_o is 1.
- R3: After tgt_rst_o falls, no rising edge appears on tgt_sck_o for at least STARTUP_CYC host cycles.
- R4: The enable frame is 0xAC 0x53 0x00 0x00, sent MSB first. The link counts as in sync (synced_o=1) when the byte received during the third byte (received bits 16..23) equals 0x53.
- R5: During a frame, each high and low phase of tgt_sck_o lasts exactly half_cyc_i host cycles, with a value of 0 treated as 1. tgt_sdo_o changes only while tgt_sck_o is low, so it is stable at every rising edge.
- R6: A command is accepted when cmd_valid_i and cmd_ready_o are both 1. The command is shifted out MSB first, and tgt_sdi_i is sampled on each rising edge. After the last falling edge, rsp_valid_o is high for exactly one cycle and rsp_data_o holds the last 8 bits received. rsp_data_o keeps that value until the next response.
- R7: After a command with cmd_wr_i=1, cmd_ready_o stays 0 for at least WR_DLY_CYC cycles, counted from the rsp_valid_o cycle. After a command with cmd_wr_i=0, cmd_ready_o is 1 in the same cycle as rsp_valid_o.
- R8: On an echo mismatch the block issues a new reset pulse, waits again and resends the enable frame.
- R9: After MAX_TRIES failed attempts, error_o goes to 1 and stays there until reset. While error_o is 1, synced_o, cmd_ready_o and tgt_sck_o are 0, and no further reset pulse is issued.
- R10: cmd_ready_o is 0 until the link is in sync. A cmd_valid_i that is raised and dropped before then launches no frame and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| half_cyc_i | input | HALF_W | Host cycles per serial-clock phase (0 acts as 1) |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Block can accept a command |
| cmd_data_i | input | 32 | Four-byte command, first byte in bits 31:24 |
| cmd_wr_i | input | 1 | Command is a write; apply the settle delay |
| rsp_valid_o | output | 1 | One-cycle pulse when a command frame completes |
| rsp_data_o | output | 8 | Last byte received from the target |
| synced_o | output | 1 | Link is in sync |
| error_o | output | 1 | All sync attempts failed (sticky) |
| tgt_rst_o | output | 1 | Target reset line |
| tgt_sck_o | output | 1 | Serial clock to the target |
| tgt_sdo_o | output | 1 | Serial data to the target |
| tgt_sdi_i | input | 1 | Serial data from the target |

## Verification
The checker asserts on every cycle the signal relations that need no knowledge of the target:
- the clock is held low while reset is pulsed;
- outgoing data is stable across every high phase and at every rising edge;
- ready never appears out of sync;
- responses are single-cycle pulses;
- the error state is sticky and quiet.

Other behaviour depends on the target's answers or on counted durations, and only the bench scenarios can show it:
- that the echo byte decides sync;
- the number of reset pulses when the first attempts fail;
- the exact phase widths for several half-period settings;
- the start-up gap and the write-settle hold-off;
- that each response carries the right byte.

// File: rtl/serprog_pkg.sv
package serprog_pkg;
  localparam int unsigned FRAME_BITS = 32;
  localparam int unsigned KEEP_BITS  = 16;
  localparam logic [FRAME_BITS-1:0] ENABLE_FRAME = 32'hAC53_0000;
  localparam logic [7:0] SYNC_BYTE = 8'h53;

  typedef enum logic [2:0] {
    ST_PWR, ST_PULSE, ST_WAIT, ST_EN, ST_IDLE, ST_CMD, ST_WDLY, ST_ERR
  } seq_state_e;
endpackage

// File: rtl/serprog_phase_tmr.sv
module serprog_phase_tmr #(
  parameter int unsigned HALF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              tick_o
);
  logic [HALF_W-1:0] cnt_q, lim;

  assign lim    = (half_i == '0) ? HALF_W'(1) : half_i;
  assign tick_o = run_i && (cnt_q == lim - HALF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + HALF_W'(1);
  end
endmodule

// File: rtl/serprog_shifter.sv
module serprog_shifter #(
  parameter int unsigned FRAME_W = 32,
  parameter int unsigned KEEP_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               tick_i,
  input  logic               sdi_i,
  output logic               busy_o,
  output logic               sck_o,
  output logic               sdo_o,
  output logic               done_o,
  output logic [KEEP_W-1:0]  rx_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1);

  logic               busy_q, sck_q, done_q;
  logic [FRAME_W-1:0] tx_q;
  logic [KEEP_W-1:0]  rx_q;
  logic [CNT_W-1:0]   bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        sck_q  <= 1'b0;
        tx_q   <= frame_i;
        bit_q  <= '0;
      end else if (busy_q && tick_i) begin
        if (!sck_q) begin
          // rising edge: target data settled after previous falling edge
          sck_q <= 1'b1;
          rx_q  <= {rx_q[KEEP_W-2:0], sdi_i};
        end else begin
          sck_q <= 1'b0;
          tx_q  <= {tx_q[FRAME_W-2:0], 1'b0};
          if (bit_q == CNT_W'(FRAME_W - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + CNT_W'(1);
          end
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign sck_o  = sck_q;
  assign sdo_o  = busy_q & tx_q[FRAME_W-1];
  assign done_o = done_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/serprog_dly.sv
module serprog_dly #(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DLY_W-1:0] len_i,
  output logic             zero_o
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= len_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - DLY_W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/serprog_host.sv
module serprog_host
  import serprog_pkg::*;
#(
  parameter int unsigned HALF_W      = 8,
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned STARTUP_CYC = CLK_HZ / 50,
  parameter int unsigned PULSE_CYC   = 16,
  parameter int unsigned MAX_TRIES   = 4,
  parameter int unsigned WR_DLY_CYC  = CLK_HZ / 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] half_cyc_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [31:0]       cmd_data_i,
  input  logic              cmd_wr_i,
  output logic              rsp_valid_o,
  output logic [7:0]        rsp_data_o,
  output logic              synced_o,
  output logic              error_o,
  output logic              tgt_rst_o,
  output logic              tgt_sck_o,
  output logic              tgt_sdo_o,
  input  logic              tgt_sdi_i
);
  localparam int unsigned DLY_MAX_A = (STARTUP_CYC > PULSE_CYC) ? STARTUP_CYC : PULSE_CYC;
  localparam int unsigned DLY_MAX   = (DLY_MAX_A > WR_DLY_CYC) ? DLY_MAX_A : WR_DLY_CYC;
  localparam int unsigned DLY_W     = $clog2(DLY_MAX + 1);
  localparam int unsigned TRY_W     = $clog2(MAX_TRIES + 1);

  seq_state_e state_q, state_d;
  logic [TRY_W-1:0]      tries_q, tries_d;
  logic                  wr_q, wr_d;
  logic                  dly_load, dly_zero;
  logic [DLY_W-1:0]      dly_len;
  logic                  sh_start, sh_busy, sh_done, tick;
  logic [FRAME_BITS-1:0] sh_frame;
  logic [KEEP_BITS-1:0]  sh_rx;
  logic                  rsp_valid_q;
  logic [7:0]            rsp_data_q;

  serprog_phase_tmr #(.HALF_W(HALF_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (sh_busy),
    .half_i (half_cyc_i),
    .tick_o (tick)
  );

  serprog_shifter #(.FRAME_W(FRAME_BITS), .KEEP_W(KEEP_BITS)) u_shf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sh_start),
    .frame_i (sh_frame),
    .tick_i  (tick),
    .sdi_i   (tgt_sdi_i),
    .busy_o  (sh_busy),
    .sck_o   (tgt_sck_o),
    .sdo_o   (tgt_sdo_o),
    .done_o  (sh_done),
    .rx_o    (sh_rx)
  );

  serprog_dly #(.DLY_W(DLY_W)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (dly_load),
    .len_i  (dly_len),
    .zero_o (dly_zero)
  );

  always_comb begin
    state_d  = state_q;
    tries_d  = tries_q;
    wr_d     = wr_q;
    dly_load = 1'b0;
    dly_len  = '0;
    sh_start = 1'b0;
    sh_frame = '0;
    unique case (state_q)
      ST_PWR: begin
        dly_load = 1'b1;
        dly_len  = DLY_W'(PULSE_CYC);
        state_d  = ST_PULSE;
      end
      ST_PULSE: if (dly_zero) begin
        dly_load = 1'b1;
        dly_len  = DLY_W'(STARTUP_CYC);
        state_d  = ST_WAIT;
      end
      ST_WAIT: if (dly_zero) begin
        sh_start = 1'b1;
        sh_frame = ENABLE_FRAME;
        state_d  = ST_EN;
      end
      ST_EN: if (sh_done) begin
        // echo of second byte arrives while third byte is sent
        if (sh_rx[15:8] == SYNC_BYTE) begin
          tries_d = '0;
          state_d = ST_IDLE;
        end else if (tries_q == TRY_W'(MAX_TRIES - 1)) begin
          state_d = ST_ERR;
        end else begin
          tries_d  = tries_q + TRY_W'(1);
          dly_load = 1'b1;
          dly_len  = DLY_W'(PULSE_CYC);
          state_d  = ST_PULSE;
        end
      end
      ST_IDLE: if (cmd_valid_i) begin
        sh_start = 1'b1;
        sh_frame = cmd_data_i;
        wr_d     = cmd_wr_i;
        state_d  = ST_CMD;
      end
      ST_CMD: if (sh_done) begin
        if (wr_q) begin
          dly_load = 1'b1;
          dly_len  = DLY_W'(WR_DLY_CYC);
          state_d  = ST_WDLY;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_WDLY: if (dly_zero) state_d = ST_IDLE;
      ST_ERR:  state_d = ST_ERR;
      default: state_d = ST_PWR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_PWR;
      tries_q     <= '0;
      wr_q        <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      state_q     <= state_d;
      tries_q     <= tries_d;
      wr_q        <= wr_d;
      rsp_valid_q <= (state_q == ST_CMD) && sh_done;
      if ((state_q == ST_CMD) && sh_done) rsp_data_q <= sh_rx[7:0];
    end
  end

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign synced_o    = (state_q == ST_IDLE) || (state_q == ST_CMD) || (state_q == ST_WDLY);
  assign error_o     = (state_q == ST_ERR);
  assign tgt_rst_o   = (state_q == ST_PULSE);
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
endmodule

// File: rtl/serprog_host_chk.sv
module serprog_host_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tgt_rst_o,
  input logic tgt_sck_o,
  input logic tgt_sdo_o,
  input logic cmd_ready_o,
  input logic synced_o,
  input logic error_o,
  input logic rsp_valid_o
);
  // R2
  rst_sck_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_rst_o |-> !tgt_sck_o);

  // R5
  sdo_hold_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_sck_o && $past(tgt_sck_o)) |-> $stable(tgt_sdo_o));

  // R5
  sdo_at_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tgt_sck_o) |-> $stable(tgt_sdo_o));

  // R10
  ready_in_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> synced_o);

  // R6
  rsp_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> error_o);

  // R9
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (!tgt_sck_o && !tgt_rst_o && !cmd_ready_o && !synced_o));
endmodule

bind serprog_host serprog_host_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tgt_rst_o   (tgt_rst_o),
  .tgt_sck_o   (tgt_sck_o),
  .tgt_sdo_o   (tgt_sdo_o),
  .cmd_ready_o (cmd_ready_o),
  .synced_o    (synced_o),
  .error_o     (error_o),
  .rsp_valid_o (rsp_valid_o)
);

// File: tb/sim_serprog_host.sv
`timescale 1ns/1ps
module sim_serprog_host;
  localparam int HALF_W  = 8;
  localparam int STARTUP = 200;
  localparam int PULSE   = 4;
  localparam int TRIES   = 3;
  localparam int WDLY    = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [HALF_W-1:0] half = 8'd3;
  logic cmd_valid = 1'b0, cmd_wr = 1'b0;
  logic [31:0] cmd_data = '0;
  logic cmd_ready, rsp_valid, synced, err, t_rst, t_sck, t_sdo;
  logic t_sdi = 1'b0;
  logic [7:0] rsp_data;

  always #4 clk = ~clk;

  serprog_host #(
    .HALF_W(HALF_W), .STARTUP_CYC(STARTUP), .PULSE_CYC(PULSE),
    .MAX_TRIES(TRIES), .WR_DLY_CYC(WDLY)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .half_cyc_i(half),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_data_i(cmd_data),
    .cmd_wr_i(cmd_wr), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .synced_o(synced), .error_o(err), .tgt_rst_o(t_rst), .tgt_sck_o(t_sck),
    .tgt_sdo_o(t_sdo), .tgt_sdi_i(t_sdi)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // target model: shifts in on rising SCK, drives on falling SCK
  int fail_left = 0;
  int bitk = 0;
  int frm_cnt = 0;
  logic [31:0] rx_t = '0, last_frm = '0;
  logic [7:0] echo_q = '0, resp_q = '0;

  initial forever begin
    @(posedge t_sck or posedge t_rst);
    if (t_rst) begin
      bitk = 0;
    end else begin
      rx_t = {rx_t[30:0], t_sdo};
      bitk++;
      if (bitk == 16) echo_q = (fail_left > 0) ? 8'h00 : rx_t[7:0];
      if (bitk == 24) resp_q = rx_t[15:8] ^ rx_t[7:0];
      if (bitk == 32) begin
        last_frm = rx_t;
        frm_cnt++;
        if (rx_t[31:24] == 8'hAC && fail_left > 0) fail_left--;
        bitk = 0;
      end
    end
  end

  initial forever begin
    @(negedge t_sck);
    if (bitk >= 16 && bitk < 24)  t_sdi = echo_q[23-bitk];
    else if (bitk >= 24)          t_sdi = resp_q[31-bitk];
    else                          t_sdi = 1'b0;
  end

  // link monitor: pulse count/width, start-up gap, phase widths
  int exp_half = 3;
  int pulse_cnt = 0, pulse_bad = 0, gap_bad = 0, ph_err = 0;
  initial begin
    int rst_run = 0, gap = 0, hi_run = 0, lo_run = 0;
    bit prev_rst = 0, prev_sck = 0, gap_on = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        prev_rst = 0; prev_sck = 0; gap_on = 0; rst_run = 0; hi_run = 0; lo_run = 0;
      end else begin
        if (t_rst) begin
          if (!prev_rst) begin pulse_cnt++; rst_run = 0; end
          rst_run++;
        end else if (prev_rst) begin
          if (rst_run < PULSE) pulse_bad++;
          gap_on = 1; gap = 0;
        end
        if (gap_on && !t_rst) begin
          if (t_sck) begin
            if (gap < STARTUP) gap_bad++;
            gap_on = 0;
          end else gap++;
        end
        if (t_sck) begin
          if (!prev_sck) begin
            if (bitk != 1 && lo_run != exp_half) ph_err++;
            lo_run = 0;
          end
          hi_run++;
        end else begin
          if (prev_sck) begin
            if (hi_run != exp_half) ph_err++;
            hi_run = 0;
          end
          lo_run++;
        end
        prev_rst = t_rst; prev_sck = t_sck;
      end
    end
  end

  // scoreboard monitor
  logic [7:0] exp_q[$];
  initial forever begin
    @(negedge clk);
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check(0, "R6", "unexpected response", rsp_data, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(rsp_data == e, "R6", "response byte", rsp_data, e);
      end
    end
  end

  task automatic boot(int fails, bit poke);
    int p0, f0;
    fail_left = fails;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check({t_rst, t_sck, t_sdo, cmd_ready, rsp_valid, synced, err} == 7'b0,
          "R1", "reset outputs", {t_rst, t_sck, t_sdo, cmd_ready, rsp_valid, synced, err}, 0);
    p0 = pulse_cnt; f0 = frm_cnt;
    if (poke) begin cmd_valid = 1'b1; cmd_data = 32'h2011_2200; end
    rst_n = 1'b1;
    if (poke) begin
      @(negedge t_rst);
      @(negedge clk);
      check(cmd_ready == 1'b0, "R10", "ready before sync", cmd_ready, 0);
      cmd_valid = 1'b0;
    end
    while (!synced && !err) @(negedge clk);
    if (fails == 0) begin
      check(synced && !err, "R4", "synced after first enable", {synced, err}, 2'b10);
      check(last_frm == 32'hAC53_0000, "R4", "enable frame bits", last_frm, 32'hAC53_0000);
      check(frm_cnt - f0 == 1, "R10", "frames before sync", frm_cnt - f0, 1);
      check(pulse_cnt - p0 == 1, "R2", "reset pulses", pulse_cnt - p0, 1);
    end else if (fails < TRIES) begin
      check(synced && !err, "R8", "synced after retries", {synced, err}, 2'b10);
      check(pulse_cnt - p0 == fails + 1, "R8", "reset pulses", pulse_cnt - p0, fails + 1);
      check(frm_cnt - f0 == fails + 1, "R8", "enable frames", frm_cnt - f0, fails + 1);
    end else begin
      check(err && !synced, "R9", "error after all tries", {err, synced}, 2'b10);
      check(pulse_cnt - p0 == TRIES, "R9", "reset pulses", pulse_cnt - p0, TRIES);
      repeat (500) @(negedge clk);
      check(err && !cmd_ready && !t_sck && !t_rst, "R9", "error sticky and quiet",
            {err, cmd_ready, t_sck, t_rst}, 4'b1000);
      check(pulse_cnt - p0 == TRIES, "R9", "no pulse after error", pulse_cnt - p0, TRIES);
    end
  endtask

  task automatic send_cmd(logic [31:0] d, bit wr);
    int n;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_data = d; cmd_wr = wr;
    exp_q.push_back(d[23:16] ^ d[15:8]);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_wr = 1'b0;
    while (!rsp_valid) @(negedge clk);
    check(last_frm == d, "R6", "frame seen by target", last_frm, d);
    if (wr) begin
      n = 0;
      while (!cmd_ready) begin n++; @(negedge clk); end
      check(n >= WDLY, "R7", "write hold-off cycles", n, WDLY);
    end else begin
      check(cmd_ready == 1'b1, "R7", "ready with read response", cmd_ready, 1);
    end
  endtask

  task automatic phase_block(int h, int eh);
    int e0;
    half = HALF_W'(h); exp_half = eh;
    e0 = ph_err;
    send_cmd(32'h2012_3400, 1'b0);
    send_cmd(32'h40AA_557E, 1'b1);
    send_cmd(32'h28C3_0F00, 1'b0);
    check(ph_err == e0, "R5", "sck phase widths", ph_err - e0, 0);
  endtask

  initial begin
    int pb0, gb0, e0;
    pb0 = pulse_bad; gb0 = gap_bad; e0 = ph_err;
    boot(0, 1'b1);
    check(pulse_bad == pb0, "R2", "reset pulse width", pulse_bad - pb0, 0);
    check(gap_bad == gb0, "R3", "start-up gap", gap_bad - gb0, 0);
    check(ph_err == e0, "R5", "enable frame phases", ph_err - e0, 0);
    phase_block(3, 3);
    phase_block(1, 1);
    phase_block(0, 1);
    phase_block(5, 5);
    check(exp_q.size() == 0, "R6", "responses outstanding", exp_q.size(), 0);
    check(rsp_data == 8'hCC, "R6", "response held", rsp_data, 8'hCC);
    half = 8'd2; exp_half = 2;
    boot(2, 1'b0);
    send_cmd(32'h30FF_0100, 1'b0);
    boot(100, 1'b0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule